// File: doc/BRIEF.md
# Transactional Undo Log Manager

This block keeps the version history for one processor core that runs hardware transactions with in-place updates. Each transactional store writes its new value directly to its home location. Before that happens, the core presents the store's address and the word's current contents to this block, which appends an undo record to a log area in memory. Committing therefore costs nothing more than emptying the log. Aborting makes the block replay the log through its memory master port, newest record first, so that every touched word gets its pre-transaction value back.

Software points the log at a region of memory by writing a base register while no transaction is open. Transactions nest flatly: inner begin/commit pairs only move a depth counter, and one log serves the whole outermost transaction. A small direct-mapped filter of recently logged word addresses keeps repeated stores to the same word out of the log. Stores flagged as I/O or system accesses inside a transaction are refused with an error pulse. A full log turns the next store that needs a record into an overflow, which starts an abort.

Top module: `undo_log_mgr`

## Requirements
- R1: After reset, in_tx, busy, done, err, overflow and mem_req are low and st_ready is high.
- R2: tx_begin outside a transaction opens one (in_tx high). Further begins and commits inside it only change a nesting depth, and in_tx falls only on the commit that matches the outermost begin.
- R3: A transactional non-I/O store that needs a record produces two memory writes in this order: the store address to base+8*n, then the old data word to base+8*n+4, where n is the number of records already in the log. st_ready stays low until both writes are acknowledged.
- R4: A store is not logged when filter slot (address/4) mod FILT_ENTRIES already holds that same word address in the current transaction; a store whose slot holds a different word is logged again and takes over the slot. The filter is emptied when a transaction opens, commits or finishes aborting.
- R5: The outermost commit issues no memory access and empties the log, so the next transaction's first record lands at base.
- R6: An abort with n>0 records reads record n-1 (address word, then data word), writes the data word to that address, and continues down to record 0; the cycle after the last write-back is acknowledged, done is high for one cycle and in_tx is low, and every touched word holds its value from before the transaction.
- R7: An abort with an empty log issues no memory access and raises done in the following cycle.
- R8: A transactional store with st_io high raises err for one cycle after it is taken and adds no record.
- R9: A store that needs a record while LOG_ENTRIES records exist raises overflow for one cycle after it is taken, is not logged, and starts the same restore as an abort.
- R10: busy is high during a restore; st_ready is low then and a tx_begin presented during the restore has no effect.
- R11: A base register write is taken only while no transaction is open; a write inside a transaction leaves the log where it was.
- R12: Stores taken outside a transaction cause no memory access, and commit or abort outside a transaction does nothing.
- R13: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the log base register |
| cfg_base | input | AW | New log base, 8-byte aligned |
| tx_begin | input | 1 | Begin a (possibly nested) transaction |
| tx_commit | input | 1 | Commit one nesting level |
| tx_abort | input | 1 | Abort the whole transaction |
| st_valid | input | 1 | Store snoop present |
| st_ready | output | 1 | Store snoop taken on this edge when st_valid is high |
| st_io | input | 1 | Store targets I/O or system space |
| st_addr | input | AW | Word address of the store |
| st_old | input | DW | Contents of the word before the store |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | DW | Read data |
| in_tx | output | 1 | A transaction is open |
| busy | output | 1 | Restore in progress |
| done | output | 1 | One-cycle pulse when an abort has finished |
| overflow | output | 1 | One-cycle pulse on log overflow |
| err | output | 1 | One-cycle pulse on a refused I/O store |

## Verification
The log writes start in the cycle after the edge that takes a store and pace themselves on mem_ack, so the bench does not predict their cycle: it queues each expected memory beat when it drives the stimulus and compares beats in order as they complete, with the memory model withholding the acknowledge every fourth cycle. err and overflow are due exactly one cycle after the taking edge, and done one cycle after the abort edge for an empty log. The bench samples those at the next falling edge. For a non-empty log, done is awaited with a bound and then the restored memory words are compared with their pre-transaction values.

// File: rtl/ulog_pkg.sv
package ulog_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOG_A = 3'd1,
    S_LOG_D = 3'd2,
    S_RD_A  = 3'd3,
    S_RD_D  = 3'd4,
    S_WB    = 3'd5
  } ulog_state_e;
endpackage

// File: rtl/ulog_nest.sv
module ulog_nest #(
  parameter int NW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic active,
  output logic outer
);
  logic [NW-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       depth_q <= '0;
    else if (clr)                     depth_q <= '0;
    else if (inc && !(&depth_q))      depth_q <= depth_q + 1'b1;
    else if (dec && depth_q != '0)    depth_q <= depth_q - 1'b1;
  end

  assign active = (depth_q != '0);
  assign outer  = (depth_q == NW'(1));

  AST_NEST_DEC_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> active); // R2
  AST_NEST_INNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && active && !clr) |=> active); // R2
endmodule

// File: rtl/ulog_filter.sv
module ulog_filter #(
  parameter int AW      = 32,
  parameter int ENTRIES = 8,
  parameter int OFF     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ins,
  input  logic [AW-1:0] ins_addr,
  input  logic [AW-1:0] look_addr,
  output logic          hit
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - OFF - IW;

  function automatic logic [IW-1:0] slot_of(input logic [AW-1:0] a);
    return a[OFF +: IW];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1 -: TW];
  endfunction

  logic          vld_q [ENTRIES];
  logic [TW-1:0] tag_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (clr) begin
        vld_q[g] <= 1'b0;
      end else if (ins && slot_of(ins_addr) == IW'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= tag_of(ins_addr);
      end
    end
  end

  assign hit = vld_q[slot_of(look_addr)] && (tag_q[slot_of(look_addr)] == tag_of(look_addr));

  logic unused_low;
  assign unused_low = &{1'b0, look_addr[OFF-1:0], ins_addr[OFF-1:0]};

  AST_FILT_EMPTY_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ins) |=> !hit); // R4
  AST_FILT_HIT_AFTER_INS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && !clr && look_addr == ins_addr) |=> (hit || !$stable(look_addr))); // R4
endmodule

// File: rtl/undo_log_mgr.sv
module undo_log_mgr #(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int LOG_ENTRIES  = 8,
  parameter int FILT_ENTRIES = 8,
  parameter int NEST_W       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic          tx_begin,
  input  logic          tx_commit,
  input  logic          tx_abort,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic          st_io,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_old,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          in_tx,
  output logic          busy,
  output logic          done,
  output logic          overflow,
  output logic          err
);
  import ulog_pkg::*;

  localparam int CW = $clog2(LOG_ENTRIES + 1);

  // byte address of word 'hi' of record 'idx'; two words per record
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] b,
                                               input logic [CW-1:0] idx,
                                               input logic          hi);
    return b + AW'({idx, hi, 2'b00});
  endfunction

  ulog_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base_q, cap_addr_q, rst_addr_q;
  logic [DW-1:0] cap_old_q, rst_data_q;
  logic          done_q, err_q, ovf_q;
  logic          tx_on, nest_outer, filt_hit;

  // named events
  logic idle, any_ctl, st_take, mem_fire;
  logic act_abort, act_commit, act_begin, commit_outer;
  logic tx_store, ev_err, ev_log, ev_ovf, last_wb, ev_close, filt_clr;

  assign idle         = (st_q == S_IDLE);
  assign any_ctl      = tx_begin | tx_commit | tx_abort;
  assign st_ready     = idle && !any_ctl;
  assign st_take      = st_valid && st_ready;
  assign mem_fire     = mem_req && mem_ack;
  assign act_abort    = idle && tx_abort && tx_on;
  assign act_commit   = idle && !tx_abort && tx_commit && tx_on;
  assign act_begin    = idle && !tx_abort && !tx_commit && tx_begin;
  assign commit_outer = act_commit && nest_outer;
  assign tx_store     = st_take && tx_on && !st_io;
  assign ev_err       = st_take && tx_on && st_io;
  assign ev_log       = tx_store && !filt_hit && (cnt_q != CW'(LOG_ENTRIES));
  assign ev_ovf       = tx_store && !filt_hit && (cnt_q == CW'(LOG_ENTRIES));
  assign last_wb      = (st_q == S_WB) && mem_fire && (cnt_q == CW'(1));
  assign ev_close     = (act_abort && cnt_q == '0) || last_wb;
  assign filt_clr     = (act_begin && !tx_on) || commit_outer || ev_close;

  ulog_nest #(.NW(NEST_W)) u_nest (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (act_begin),
    .dec    (act_commit),
    .clr    (ev_close),
    .active (tx_on),
    .outer  (nest_outer)
  );

  ulog_filter #(.AW(AW), .ENTRIES(FILT_ENTRIES), .OFF(2)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (filt_clr),
    .ins       (ev_log),
    .ins_addr  (st_addr),
    .look_addr (st_addr),
    .hit       (filt_hit)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: begin
        if ((act_abort && cnt_q != '0) || ev_ovf) st_d = S_RD_A;
        else if (ev_log)                           st_d = S_LOG_A;
      end
      S_LOG_A: if (mem_ack) st_d = S_LOG_D;
      S_LOG_D: if (mem_ack) st_d = S_IDLE;
      S_RD_A:  if (mem_ack) st_d = S_RD_D;
      S_RD_D:  if (mem_ack) st_d = S_WB;
      S_WB:    if (mem_ack) st_d = (cnt_q == CW'(1)) ? S_IDLE : S_RD_A;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      base_q     <= '0;
      cap_addr_q <= '0;
      cap_old_q  <= '0;
      rst_addr_q <= '0;
      rst_data_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= ev_close;
      err_q  <= ev_err;
      ovf_q  <= ev_ovf;
      if (cfg_we && idle && !tx_on) base_q <= cfg_base;
      if (ev_log) begin
        cap_addr_q <= st_addr;
        cap_old_q  <= st_old;
      end
      if (commit_outer)                    cnt_q <= '0;
      else if (st_q == S_LOG_D && mem_ack) cnt_q <= cnt_q + 1'b1;
      else if (st_q == S_WB && mem_ack)    cnt_q <= cnt_q - 1'b1;
      if (st_q == S_RD_A && mem_ack) rst_addr_q <= AW'(mem_rdata);
      if (st_q == S_RD_D && mem_ack) rst_data_q <= mem_rdata;
    end
  end

  // memory master
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      S_LOG_A: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = slot_addr(base_q, cnt_q, 1'b0); mem_wdata = DW'(cap_addr_q);
      end
      S_LOG_D: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = slot_addr(base_q, cnt_q, 1'b1); mem_wdata = cap_old_q;
      end
      S_RD_A: begin
        mem_req = 1'b1;
        mem_addr = slot_addr(base_q, cnt_q - 1'b1, 1'b0);
      end
      S_RD_D: begin
        mem_req = 1'b1;
        mem_addr = slot_addr(base_q, cnt_q - 1'b1, 1'b1);
      end
      S_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = rst_addr_q; mem_wdata = rst_data_q;
      end
      default: ;
    endcase
  end

  assign in_tx    = tx_on;
  assign busy     = (st_q == S_RD_A) || (st_q == S_RD_D) || (st_q == S_WB);
  assign done     = done_q;
  assign err      = err_q;
  assign overflow = ovf_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R13
  AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    commit_outer |=> !mem_req); // R5
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !st_ready); // R10
  AST_LOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LOG_ENTRIES)); // R9
  AST_OVF_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> busy); // R9
  AST_ERR_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> !mem_req); // R8
  AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_tx && cnt_q == '0)); // R6
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !tx_on) |=> !mem_req); // R12
endmodule

// File: tb/tb_undo_log_mgr.sv
module tb_undo_log_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NREC = 8;
  localparam int NFILT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        tx_begin = 1'b0, tx_commit = 1'b0, tx_abort = 1'b0;
  logic        st_valid = 1'b0, st_io = 1'b0;
  logic [31:0] st_addr = '0, st_old = '0;
  logic        st_ready;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        in_tx, busy, done, overflow, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  undo_log_mgr #(.AW(32), .DW(32), .LOG_ENTRIES(NREC), .FILT_ENTRIES(NFILT), .NEST_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort),
    .st_valid(st_valid), .st_ready(st_ready), .st_io(st_io), .st_addr(st_addr), .st_old(st_old),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .in_tx(in_tx), .busy(busy), .done(done), .overflow(overflow), .err(err));

  // memory model with a stall every fourth cycle
  logic [31:0] mem_arr [256];
  logic [1:0]  ack_ctr = '0;
  always @(posedge clk) ack_ctr <= ack_ctr + 2'd1;
  assign mem_ack   = mem_req && (ack_ctr != 2'd3);
  assign mem_rdata = mem_arr[mem_addr[9:2]];
  always @(posedge clk) if (rst_n && mem_req && mem_ack && mem_we) mem_arr[mem_addr[9:2]] = mem_wdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { bit we; logic [31:0] a; logic [31:0] d; string rq; } beat_t;
  beat_t expq[$];

  task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d, input string rq);
    beat_t b;
    b.we = we; b.a = a; b.d = d; b.rq = rq;
    expq.push_back(b);
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (expq.size() == 0) begin
        chk(0, "R12", "unexpected memory beat addr", mem_addr, 32'h0);
      end else begin
        beat_t b;
        b = expq.pop_front();
        chk(mem_we == b.we, b.rq, "beat direction", {31'd0, mem_we}, {31'd0, b.we});
        chk(mem_addr == b.a, b.rq, "beat address", mem_addr, b.a);
        if (b.we) chk(mem_wdata == b.d, b.rq, "beat data", mem_wdata, b.d);
      end
    end
  end

  // reference model
  logic [31:0] m_base = '0;
  int          m_depth = 0, m_cnt = 0;
  logic [31:0] m_ea [$];
  logic [31:0] m_eo [$];
  logic [31:0] orig [logic [31:0]];
  bit          f_v [NFILT];
  logic [31:0] f_tag [NFILT];

  function automatic logic [31:0] rec_addr(input int idx, input int hi);
    return m_base + 32'(idx * 8 + hi * 4);
  endfunction

  task automatic model_clear();
    m_cnt = 0;
    m_ea.delete(); m_eo.delete(); orig.delete();
    for (int i = 0; i < NFILT; i++) f_v[i] = 0;
  endtask

  task automatic push_restore();
    for (int i = m_cnt - 1; i >= 0; i--) begin
      push(0, rec_addr(i, 0), 32'h0, "R6");
      push(0, rec_addr(i, 1), 32'h0, "R6");
      push(1, m_ea[i], m_eo[i], "R6");
    end
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (!st_ready) begin @(negedge clk); #1; end
  endtask

  task automatic wait_close(input string rq);
    bit seen = 0;
    for (int n = 0; n < 600 && !seen; n++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, rq, "done pulse after restore", {31'd0, seen}, 32'd1);
    chk(!in_tx, rq, "in_tx after restore", {31'd0, in_tx}, 32'd0);
    chk(expq.size() == 0, rq, "restore beats left", 32'(expq.size()), 32'd0);
    foreach (orig[k]) chk(mem_arr[k[9:2]] == orig[k], "R6", "restored word", mem_arr[k[9:2]], orig[k]);
    m_depth = 0;
    model_clear();
  endtask

  task automatic t_store(input logic [31:0] a, input logic [31:0] nv, input bit io);
    int slot;
    bit exp_err, exp_ovf;
    logic [31:0] old;
    @(negedge clk);
    st_valid = 1; st_addr = a; st_io = io; st_old = mem_arr[a[9:2]];
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    old = st_old; exp_err = 0; exp_ovf = 0;
    if (m_depth > 0) begin
      if (io) exp_err = 1;
      else begin
        slot = int'((a >> 2) % NFILT);
        if (f_v[slot] && f_tag[slot] == a) begin
          // R4: already recorded
        end else if (m_cnt == NREC) begin
          exp_ovf = 1;
          push_restore();
        end else begin
          push(1, rec_addr(m_cnt, 0), a, "R3");
          push(1, rec_addr(m_cnt, 1), old, "R3");
          m_ea.push_back(a); m_eo.push_back(old);
          if (!orig.exists(a)) orig[a] = old;
          m_cnt++;
          f_v[slot] = 1; f_tag[slot] = a;
        end
      end
    end
    if (!io && !exp_ovf) mem_arr[a[9:2]] = nv;
    @(negedge clk);
    st_valid = 0; st_io = 0;
    if (io) chk(err == exp_err, "R8", "err pulse", {31'd0, err}, {31'd0, exp_err});
    if (exp_ovf) chk(overflow == 1'b1, "R9", "overflow pulse", {31'd0, overflow}, 32'd1);
  endtask

  task automatic t_begin();
    wait_idle();
    tx_begin = 1;
    @(posedge clk); #1; tx_begin = 0;
    if (m_depth == 0) model_clear();
    m_depth++;
    @(negedge clk);
    chk(in_tx == 1'b1, "R2", "in_tx after begin", {31'd0, in_tx}, 32'd1);
  endtask

  task automatic t_commit();
    bit quiet = 1;
    wait_idle();
    tx_commit = 1;
    @(posedge clk); #1; tx_commit = 0;
    if (m_depth > 0) begin
      m_depth--;
      if (m_depth == 0) model_clear();
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (mem_req) quiet = 0;
    end
    chk(quiet, "R5", "no traffic after commit", {31'd0, quiet}, 32'd1);
    chk(in_tx == (m_depth > 0), "R2", "in_tx after commit", {31'd0, in_tx}, {31'd0, m_depth > 0});
  endtask

  task automatic t_abort();
    bool_t: begin end
    wait_idle();
    if (m_depth > 0 && m_cnt > 0) push_restore();
    tx_abort = 1;
    @(posedge clk); #1; tx_abort = 0;
    if (m_depth == 0) begin
      @(negedge clk);
      chk(done == 1'b0, "R12", "done after abort outside tx", {31'd0, done}, 32'd0);
    end else if (m_cnt == 0) begin
      @(negedge clk);
      chk(done == 1'b1, "R7", "done after empty abort", {31'd0, done}, 32'd1);
      chk(!in_tx, "R7", "in_tx after empty abort", {31'd0, in_tx}, 32'd0);
      m_depth = 0;
      model_clear();
    end else begin
      wait_close("R6");
    end
  endtask

  task automatic t_cfg(input logic [31:0] b);
    wait_idle();
    cfg_we = 1; cfg_base = b;
    @(posedge clk); #1; cfg_we = 0;
    if (m_depth == 0) m_base = b;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 32'hA000_0000 | 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!in_tx && !busy && !done && !err && !overflow, "R1", "status after reset",
        {27'd0, in_tx, busy, done, err, overflow}, 32'd0);
    chk(!mem_req && st_ready, "R1", "port idle after reset", {30'd0, mem_req, st_ready}, 32'd1);
    rst_n = 1;

    // commit path, repeated word
    t_cfg(32'h100);
    t_begin();
    t_store(32'h200, 32'h1111_0000, 0);
    t_store(32'h204, 32'h1111_0004, 0);
    t_store(32'h200, 32'h1111_1000, 0);   // R4 no second record
    t_commit();
    chk(mem_arr[32'h200 >> 2] == 32'h1111_1000, "R5", "committed value stays", mem_arr[32'h200 >> 2], 32'h1111_1000);

    // nesting, ignored base write, abort replay
    t_begin();
    t_store(32'h208, 32'h2222_0008, 0);   // R5 first record at base again
    t_begin();
    t_store(32'h20C, 32'h2222_000C, 0);
    t_commit();                          // inner, R2
    t_cfg(32'h1C0);                      // R11 ignored
    t_store(32'h210, 32'h2222_0010, 0);
    t_abort();

    // empty abort
    t_begin();
    t_abort();

    // aliasing in the filter, refused I/O store
    t_begin();
    t_store(32'h200, 32'h3333_0000, 0);
    t_store(32'h220, 32'h3333_0020, 0);
    t_store(32'h200, 32'h3333_1000, 0);   // R4 slot taken by 0x220
    t_store(32'h2F0, 32'h3333_00F0, 1);   // R8
    t_commit();

    // overflow and begin during restore
    t_begin();
    for (int i = 0; i < NREC; i++) t_store(32'h240 + 32'(i * 4), 32'h4444_0000 | 32'(i), 0);
    t_store(32'h260, 32'h4444_0060, 0);   // R9
    chk(busy == 1'b1, "R10", "busy during restore", {31'd0, busy}, 32'd1);
    chk(st_ready == 1'b0, "R10", "st_ready during restore", {31'd0, st_ready}, 32'd0);
    tx_begin = 1;
    @(negedge clk);
    tx_begin = 0;
    wait_close("R9");
    @(negedge clk);
    chk(!in_tx, "R10", "begin during restore dropped", {31'd0, in_tx}, 32'd0);

    // activity outside a transaction
    t_store(32'h280, 32'h5555_0080, 0);
    t_abort();
    t_commit();
    chk(mem_arr[32'h280 >> 2] == 32'h5555_0080, "R12", "store outside tx kept", mem_arr[32'h280 >> 2], 32'h5555_0080);

    // new base taken between transactions
    t_cfg(32'h180);
    t_begin();
    t_store(32'h230, 32'h6666_0030, 0);   // R11 record at 0x180
    t_abort();

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R3", "scoreboard drained", 32'(expq.size()), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule